// File: doc/BRIEF.md
# Masked Calendar Alarm Interrupt Unit

This unit watches a calendar time supplied by a separate counter and raises an interrupt when the time reaches a programmed alarm instant. It holds seven alarm field registers: seconds, minutes, hours, day of month, day of week, month and year. It also holds a comparison mask, an enable register, a status register and a sticky wake-up pending flag. Software reaches all of them through a simple word-wide register bus.

The comparison runs only on the cycle in which the one-second tick strobes the live time, so each matching second yields a single event. Any field whose mask bit is set is left out of the comparison. Ordinary use masks the day of week.

Alarm field writes land in staging registers. They reach the live alarm only when the shared write-trigger pulse arrives, so a partly written alarm is never compared. In one-shot mode the unit clears its own alarm enable when the alarm fires. Each alarm hit also sets a wake-up pending flag. That flag survives status reads and clears only when software writes it.

Top module: `cal_alarm`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: A write to an alarm field at word address 8+i changes only a staging copy. The field used for comparison and returned on read takes the staged value only on a cycle with `trig` high, and all seven fields transfer together. Field order by index i is 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 day of week, 5 month, 6 year.
- R3: The alarm condition is evaluated only on cycles with `tick` high. A matching live time with `tick` low sets nothing.
- R4: Each field is compared only on its low bits: 6 for seconds, 6 for minutes, 5 for hours, 5 for day of month, 3 for day of week, 4 for month and 7 for year. The upper bits of a field word are stored and read back but have no effect on the match.
- R5: Mask register (address 2) bit i removes field i from the comparison, so bit 4 removes the day of week. A masked field always counts as equal.
- R6: A match while enable bit 0 (address 0) is clear sets neither status nor pending.
- R7: If enable bits 0 and 2 are both set, a match clears enable bit 0 on the same clock edge that sets status bit 0. Later matches then set nothing.
- R8: Status (address 1) bit 0 is set on the clock edge after an enabled match. A read with `bus_rd` high returns the current value and clears the register at the next edge. When a set and a clearing read coincide, the set wins.
- R9: An enabled match sets pending bit 4 at address 3. Status reads do not clear it. Writing a 0 to bit 4 leaves it set, and writing a 1 to bit 4 clears it.
- R10: `irq` is high exactly when (status bit 0 and enable bit 0) or (status bit 3 and enable bit 3).
- R11: A cycle with `lp_evt` high sets status bit 3, which is cleared by a status read like bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on read) |
| bus_addr | input | AW (4) | Word address |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data for `bus_addr`, combinational |
| tick | input | 1 | One-second strobe; live time is valid this cycle |
| trig | input | 1 | Write-trigger pulse that commits staged alarm fields |
| lp_evt | input | 1 | Low-power event pulse |
| now_sec | input | 6 | Live seconds |
| now_min | input | 6 | Live minutes |
| now_hour | input | 5 | Live hours |
| now_dom | input | 5 | Live day of month |
| now_dow | input | 3 | Live day of week |
| now_mon | input | 4 | Live month |
| now_year | input | 7 | Live year offset |
| irq | output | 1 | Level interrupt, active high |

## Verification
A table sweeps mask patterns against a live time that differs in exactly one field. This catches a mask bit wired to the wrong field, which would pass or block the wrong mismatch. The seconds alarm word carries set upper bits; a design that compares the full word would never match. Staging is exercised by changing a field without a trigger and checking that the old value still matches. A design that lets writes go straight to the live alarm would lose that match.

Other directed cases cover a status read landing on the same edge as a hit, which a clear-priority design would drop, and one-shot mode, where a design that fails to disarm fires again on the next match. They also check that the pending flag survives status reads and zero writes.

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick,
  input  logic          trig,
  input  logic          lp_evt,
  input  logic [5:0]    now_sec,
  input  logic [5:0]    now_min,
  input  logic [4:0]    now_hour,
  input  logic [4:0]    now_dom,
  input  logic [2:0]    now_dow,
  input  logic [3:0]    now_mon,
  input  logic [6:0]    now_year,
  output logic          irq
);
  localparam int NF = 7;
  localparam logic [AW-1:0] A_EN  = AW'(0);
  localparam logic [AW-1:0] A_ST  = AW'(1);
  localparam logic [AW-1:0] A_MSK = AW'(2);
  localparam logic [AW-1:0] A_PND = AW'(3);
  localparam int            A_FLD = 8;
  localparam logic [NF-1:0][2:0] FW = {3'd7, 3'd4, 3'd3, 3'd5, 3'd5, 3'd6, 3'd6};

  logic [NF-1:0][DW-1:0] shd_q, act_q;
  logic [NF-1:0]         msk_q, fmatch;
  logic [6:0]            now_f [NF];
  logic en_al_q, en_os_q, en_lp_q, st_al_q, st_lp_q, pend_q;
  logic hit, al_set, st_clr;

  assign now_f[0] = {1'b0, now_sec};
  assign now_f[1] = {1'b0, now_min};
  assign now_f[2] = {2'b0, now_hour};
  assign now_f[3] = {2'b0, now_dom};
  assign now_f[4] = {4'b0, now_dow};
  assign now_f[5] = {3'b0, now_mon};
  assign now_f[6] = now_year;

  always_comb begin
    for (int i = 0; i < NF; i++) begin
      logic [6:0] fm;
      fm = 7'((8'd1 << FW[i]) - 8'd1);
      fmatch[i] = msk_q[i] | ((act_q[i][6:0] & fm) == now_f[i]);
    end
  end

  assign hit    = tick & (&fmatch);
  assign al_set = hit & en_al_q;
  assign st_clr = bus_rd && bus_addr == A_ST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_q   <= '0;
      act_q   <= '0;
      msk_q   <= '0;
      en_al_q <= 1'b0;
      en_os_q <= 1'b0;
      en_lp_q <= 1'b0;
      st_al_q <= 1'b0;
      st_lp_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      for (int i = 0; i < NF; i++)
        if (bus_wr && bus_addr == AW'(A_FLD + i)) shd_q[i] <= bus_wdata;
      if (trig) act_q <= shd_q;
      if (bus_wr && bus_addr == A_MSK) msk_q <= bus_wdata[NF-1:0];
      if (bus_wr && bus_addr == A_EN) begin
        en_al_q <= bus_wdata[0];
        en_os_q <= bus_wdata[2];
        en_lp_q <= bus_wdata[3];
      end
      if (al_set && en_os_q) en_al_q <= 1'b0;
      if (st_clr) begin
        st_al_q <= 1'b0;
        st_lp_q <= 1'b0;
      end
      if (al_set) st_al_q <= 1'b1;
      if (lp_evt) st_lp_q <= 1'b1;
      if (bus_wr && bus_addr == A_PND && bus_wdata[4]) pend_q <= 1'b0;
      if (al_set) pend_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_EN:    bus_rdata = DW'({en_lp_q, en_os_q, 1'b0, en_al_q});
      A_ST:    bus_rdata = DW'({st_lp_q, 2'b0, st_al_q});
      A_MSK:   bus_rdata = DW'(msk_q);
      A_PND:   bus_rdata = DW'({pend_q, 4'b0});
      default: begin
        for (int i = 0; i < NF; i++)
          if (bus_addr == AW'(A_FLD + i)) bus_rdata = act_q[i];
      end
    endcase
  end

  assign irq = (st_al_q & en_al_q) | (st_lp_q & en_lp_q);
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            tick,
  input logic            trig,
  input logic            hit,
  input logic            en_al,
  input logic            en_os,
  input logic            en_lp,
  input logic            st_al,
  input logic            pend,
  input logic [7*DW-1:0] act,
  input logic            irq
);
  localparam logic [AW-1:0] A_EN  = AW'(0);
  localparam logic [AW-1:0] A_PND = AW'(3);

  AST_COMMIT_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(act)); // R2
  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !st_al && !tick |=> !st_al); // R3
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !st_al && !en_al |=> !st_al); // R6
  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    hit && en_al && en_os |=> !en_al && st_al); // R7
  AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    hit && en_al |=> st_al); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !(bus_wr && bus_addr == A_PND && bus_wdata[4]) |=> pend); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_al && !en_lp |-> !irq); // R10
  AST_EN_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !en_al && !(bus_wr && bus_addr == A_EN) |=> !en_al); // R7
endmodule

bind cal_alarm cal_alarm_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tick(tick), .trig(trig), .hit(hit),
  .en_al(en_al_q), .en_os(en_os_q), .en_lp(en_lp_q), .st_al(st_al_q),
  .pend(pend_q), .act(act_q), .irq(irq)
);

// File: tb/tb_cal_alarm.sv
module tb_cal_alarm;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, tick = 1'b0, trig = 1'b0, lp_evt = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        irq;
  logic [6:0]  nowv [7];
  int checks = 0, errors = 0;
  logic [15:0] rv;

  localparam logic [6:0] ALM [7] = '{7'd30, 7'd15, 7'd10, 7'd20, 7'd3, 7'd6, 7'd50};
  // {mask[6:0], perturbed field (7 = none), expected match}
  localparam logic [10:0] VEC [11] = '{
    {7'h00, 3'd7, 1'b1}, {7'h00, 3'd0, 1'b0}, {7'h01, 3'd0, 1'b1},
    {7'h10, 3'd4, 1'b1}, {7'h10, 3'd5, 1'b0}, {7'h40, 3'd6, 1'b1},
    {7'h7F, 3'd2, 1'b1}, {7'h08, 3'd1, 1'b0}, {7'h20, 3'd5, 1'b1},
    {7'h04, 3'd2, 1'b1}, {7'h02, 3'd3, 1'b0}};

  always #5 clk = ~clk;

  cal_alarm dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .trig(trig), .lp_evt(lp_evt),
    .now_sec(nowv[0][5:0]), .now_min(nowv[1][5:0]), .now_hour(nowv[2][4:0]),
    .now_dom(nowv[3][4:0]), .now_dow(nowv[4][2:0]), .now_mon(nowv[5][3:0]),
    .now_year(nowv[6]), .irq(irq));

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic take_status(output logic [15:0] d);
    @(negedge clk); bus_addr = 4'd1; #1 d = bus_rdata; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1; @(negedge clk); trig = 1'b0;
  endtask

  task automatic tick_once();
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic now_alarm();
    for (int i = 0; i < 7; i++) nowv[i] = ALM[i];
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) nowv[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek(4'd0, rv); check("R1 enable", rv, 16'h0);
    peek(4'd1, rv); check("R1 status", rv, 16'h0);
    peek(4'd3, rv); check("R1 pending", rv, 16'h0);
    peek(4'd8, rv); check("R1 alarm sec", rv, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);

    // R2 staging, R4 upper bits kept
    wr(4'd8, 16'hFF1E);
    peek(4'd8, rv); check("R2 field before trigger", rv, 16'h0);
    for (int i = 1; i < 7; i++) wr(4'(8 + i), {9'd0, ALM[i]});
    pulse_trig();
    peek(4'd8, rv); check("R4 upper bits read back", rv, 16'hFF1E);
    peek(4'd14, rv); check("R2 year after trigger", rv, 16'd50);
    wr(4'd0, 16'h0001);

    // R5 mask table, R4 comparison width
    for (int v = 0; v < 11; v++) begin
      wr(4'd2, {9'd0, VEC[v][10:4]});
      now_alarm();
      if (VEC[v][3:1] != 3'd7) nowv[VEC[v][3:1]] = ALM[VEC[v][3:1]] ^ 7'd1;
      tick_once();
      take_status(rv);
      check($sformatf("R5 vector %0d", v), rv, {15'd0, VEC[v][0]});
    end
    wr(4'd2, 16'h0);
    wr(4'd3, 16'h0010);
    now_alarm();

    // R3 no tick
    repeat (3) @(negedge clk);
    peek(4'd1, rv); check("R3 no tick no status", rv, 16'h0);

    // R10 irq, R9 pending
    tick_once();
    #1 check("R10 irq on match", {15'd0, irq}, 16'h1);
    peek(4'd3, rv); check("R9 pending set", rv, 16'h0010);
    take_status(rv); check("R8 status read value", rv, 16'h0001);
    peek(4'd1, rv); check("R8 status cleared", rv, 16'h0);
    #1 check("R10 irq after clear", {15'd0, irq}, 16'h0);
    peek(4'd3, rv); check("R9 pending survives read", rv, 16'h0010);
    wr(4'd3, 16'h0000);
    peek(4'd3, rv); check("R9 zero write keeps", rv, 16'h0010);
    wr(4'd3, 16'h0010);
    peek(4'd3, rv); check("R9 one write clears", rv, 16'h0);

    // R6 disabled
    wr(4'd0, 16'h0000);
    tick_once();
    peek(4'd1, rv); check("R6 no status", rv, 16'h0);
    peek(4'd3, rv); check("R6 no pending", rv, 16'h0);

    // R7 one-shot
    wr(4'd0, 16'h0005);
    tick_once();
    peek(4'd0, rv); check("R7 enable disarmed", rv, 16'h0004);
    peek(4'd1, rv); check("R7 status set", rv, 16'h0001);
    #1 check("R10 irq gated by cleared enable", {15'd0, irq}, 16'h0);
    take_status(rv);
    tick_once();
    peek(4'd1, rv); check("R7 second match ignored", rv, 16'h0);

    // R2 staged write does not affect compare until trigger
    wr(4'd0, 16'h0001);
    wr(4'd8, 16'd31);
    tick_once();
    take_status(rv); check("R2 old alarm still active", rv, 16'h0001);
    pulse_trig();
    tick_once();
    take_status(rv); check("R2 new alarm after trigger", rv, 16'h0);
    wr(4'd8, 16'd30);
    pulse_trig();

    // R8 set beats clear
    @(negedge clk); bus_addr = 4'd1; bus_rd = 1'b1; tick = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tick = 1'b0;
    peek(4'd1, rv); check("R8 set wins over read clear", rv, 16'h0001);
    take_status(rv);

    // R11 low-power event
    wr(4'd0, 16'h0008);
    @(negedge clk); lp_evt = 1'b1; @(negedge clk); lp_evt = 1'b0;
    peek(4'd1, rv); check("R11 lp status", rv, 16'h0008);
    #1 check("R10 irq from lp", {15'd0, irq}, 16'h1);
    take_status(rv);
    peek(4'd1, rv); check("R11 lp cleared", rv, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule